// File: doc/BRIEF.md
# Edge-Detecting Level-0 Trigger Latency Pipeline

This block sits between the binary discriminator outputs of a strip readout front-end and its event buffer. On every bunch-crossing clock it samples one bit per channel. Masked channels are forced low. Each channel is then reduced to a one-cycle marker that shows a 0-to-1 transition. The resulting word is written into a circular memory, so the recent history of crossings is always held.

A synchronous level-0 accept pulse asks for the word recorded a programmable number of crossings before the pulse. The block reads that single entry and, one clock later, presents it with a valid strobe and an event number. The event number counts accepts. Edge detection is done before storage, so every accept needs exactly one read. Accepts may arrive on consecutive crossings with no extra control logic.

Top module: `lvl0_edge_pipeline`

## Requirements
- R1: A channel whose mask bit is 1 is treated as 0 before edge detection, so it never shows a marker in any extracted word.
- R2: The stored marker for a channel is 1 only when that channel's masked sample is 1 on this crossing and was 0 on the previous crossing. Reset clears the remembered previous sample to 0. A channel held high therefore yields one marker.
- R3: For an accept sampled on crossing k with latency L in the range 1 to DEPTH-1, the extracted word equals the marker word of crossing k-L. Storage addresses wrap modulo DEPTH.
- R4: `ev_valid_o` is high in the clock cycle right after each crossing on which `l0_i` was sampled high, and low in every other cycle.
- R5: Accepts on consecutive crossings each yield their own extraction, one per cycle, each from its own crossing.
- R6: The first event after reset carries identifier 0. Each later event carries the previous identifier plus 1, modulo 2^ID_W.
- R7: While `ev_valid_o` is low, `ev_word_o` and `ev_id_o` keep their last values.
- R8: While reset is asserted, and on the first cycle after it, `ev_valid_o`, `ev_word_o` and `ev_id_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_i | input | NCH | Discriminator sample, one bit per channel |
| mask_i | input | NCH | Per-channel mask, 1 forces the channel to 0 |
| lat_i | input | AW | Latency in crossings, AW = clog2(DEPTH) |
| l0_i | input | 1 | Level-0 accept pulse |
| ev_valid_o | output | 1 | Extracted event is valid this cycle |
| ev_word_o | output | NCH | Extracted marker word |
| ev_id_o | output | ID_W | Level-0 event identifier |

## Verification
The bench builds the block with 8 channels, a 16-entry ring and a 4-bit identifier. This makes every legal latency from 1 to 15 reachable in one sweep. The write pointer wraps dozens of times, and the identifier rolls over more than once within a short burst of back-to-back accepts. Random hit words from a shift-register generator are run through an arithmetic edge-and-mask model. A held-high pattern, a partial mask and a mid-run reset cover the edge-marker, masking and restart cases.

// File: rtl/l0pipe_pkg.sv
package l0pipe_pkg;

   // Position that lies 'back' steps behind 'pos' on a ring of 'depth' entries
   function automatic int unsigned ring_back(input int unsigned pos,
                                             input int unsigned back,
                                             input int unsigned depth);
      return (pos + depth - (back % depth)) % depth;
   endfunction

   // Position following 'pos' on a ring of 'depth' entries
   function automatic int unsigned ring_next(input int unsigned pos,
                                             input int unsigned depth);
      return (pos + 1) % depth;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tp_edge_stage.sv
module tp_edge_stage #(
   parameter int NCH = 256
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [NCH-1:0] hit_i,
   input  logic [NCH-1:0] mask_i,
   output logic [NCH-1:0] edge_o
);
   logic [NCH-1:0] gated;
   logic [NCH-1:0] prev_q;
   logic           primed_q;

   assign gated  = hit_i & ~mask_i;
   assign edge_o = gated & ~prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         prev_q   <= gated;
         primed_q <= 1'b1;
      end
   end

   // A marker can never repeat on the same channel in two successive crossings
   assert_no_double_edge_R2 : assert property (@(posedge clk) disable iff (rst)
      primed_q |-> ((edge_o & $past(edge_o)) == '0));

endmodule

// File: rtl/tp_ring_addr.sv
module tp_ring_addr #(
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] lat_i,
   output logic [AW-1:0] wr_ptr_o,
   output logic [AW-1:0] rd_addr_o
);
   logic [AW-1:0] wr_q;
   logic          primed_q;

   generate
      if (l0pipe_pkg::is_pow2(DEPTH)) begin : g_pow2
         always_ff @(posedge clk) begin
            if (rst) wr_q <= '0;
            else     wr_q <= wr_q + 1'b1;
         end
         assign rd_addr_o = wr_q - lat_i;
      end else begin : g_any
         always_ff @(posedge clk) begin
            if (rst) wr_q <= '0;
            else     wr_q <= AW'(l0pipe_pkg::ring_next(32'(wr_q), DEPTH));
         end
         assign rd_addr_o = AW'(l0pipe_pkg::ring_back(32'(wr_q), 32'(lat_i), DEPTH));
      end
   endgenerate

   assign wr_ptr_o = wr_q;

   always_ff @(posedge clk) begin
      if (rst) primed_q <= 1'b0;
      else     primed_q <= 1'b1;
   end

   assert_ptr_step_R3 : assert property (@(posedge clk) disable iff (rst)
      primed_q |-> (32'(wr_q) == ((32'($past(wr_q)) + 1) % DEPTH)));

   assert_rd_offset_R3 : assert property (@(posedge clk) disable iff (rst)
      (32'(lat_i) < DEPTH) |-> (((32'(rd_addr_o) + 32'(lat_i)) % DEPTH) == 32'(wr_q)));

endmodule

// File: rtl/tp_ring_mem.sv
module tp_ring_mem #(
   parameter int W     = 256,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [W-1:0]  wdata_i,
   input  logic          re_i,
   input  logic [AW-1:0] raddr_i,
   output logic [W-1:0]  rdata_o
);
   logic [W-1:0] store [DEPTH];
   logic         primed_q;

   always_ff @(posedge clk) begin
      if (we_i) store[waddr_i] <= wdata_i;
   end

   // Read happens before the write of the same edge lands
   always_ff @(posedge clk) begin
      if (rst)       rdata_o <= '0;
      else if (re_i) rdata_o <= store[raddr_i];
   end

   always_ff @(posedge clk) begin
      if (rst) primed_q <= 1'b0;
      else     primed_q <= 1'b1;
   end

   assert_word_hold_R7 : assert property (@(posedge clk) disable iff (rst)
      (primed_q && !$past(re_i)) |-> $stable(rdata_o));

endmodule

// File: rtl/tp_l0_tagger.sv
module tp_l0_tagger #(
   parameter int ID_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            l0_i,
   output logic            valid_o,
   output logic [ID_W-1:0] id_o
);
   logic [ID_W-1:0] cnt_q;
   logic            primed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         id_o    <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= l0_i;
         if (l0_i) begin
            id_o  <= cnt_q;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) primed_q <= 1'b0;
      else     primed_q <= 1'b1;
   end

   assert_valid_lag_R4 : assert property (@(posedge clk) disable iff (rst)
      primed_q |-> (valid_o == $past(l0_i)));

   assert_id_step_R6 : assert property (@(posedge clk) disable iff (rst)
      (primed_q && valid_o && $past(valid_o)) |-> (id_o == $past(id_o) + 1'b1));

   assert_id_hold_R7 : assert property (@(posedge clk) disable iff (rst)
      (primed_q && !valid_o) |-> $stable(id_o));

endmodule

// File: rtl/lvl0_edge_pipeline.sv
module lvl0_edge_pipeline #(
   parameter int NCH   = 256,
   parameter int DEPTH = 512,
   parameter int ID_W  = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NCH-1:0]  hit_i,
   input  logic [NCH-1:0]  mask_i,
   input  logic [AW-1:0]   lat_i,
   input  logic            l0_i,
   output logic            ev_valid_o,
   output logic [NCH-1:0]  ev_word_o,
   output logic [ID_W-1:0] ev_id_o
);
   generate
      if (NCH < 1)   begin : g_bad_nch   $error("NCH must be at least 1");   end
      if (DEPTH < 2) begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (ID_W < 1)  begin : g_bad_idw   $error("ID_W must be at least 1");  end
   endgenerate

   logic [NCH-1:0] marks;
   logic [AW-1:0]  wr_ptr;
   logic [AW-1:0]  rd_addr;

   tp_edge_stage #(.NCH(NCH)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .hit_i  (hit_i),
      .mask_i (mask_i),
      .edge_o (marks)
   );

   tp_ring_addr #(.DEPTH(DEPTH)) u_addr (
      .clk       (clk),
      .rst       (rst),
      .lat_i     (lat_i),
      .wr_ptr_o  (wr_ptr),
      .rd_addr_o (rd_addr)
   );

   tp_ring_mem #(.W(NCH), .DEPTH(DEPTH)) u_mem (
      .clk     (clk),
      .rst     (rst),
      .we_i    (~rst),
      .waddr_i (wr_ptr),
      .wdata_i (marks),
      .re_i    (l0_i & ~rst),
      .raddr_i (rd_addr),
      .rdata_o (ev_word_o)
   );

   tp_l0_tagger #(.ID_W(ID_W)) u_tag (
      .clk     (clk),
      .rst     (rst),
      .l0_i    (l0_i),
      .valid_o (ev_valid_o),
      .id_o    (ev_id_o)
   );

endmodule

// File: tb/test_lvl0_edge_pipeline.sv
`timescale 1ns/1ps
module test_lvl0_edge_pipeline;
   localparam int N  = 8;
   localparam int D  = 16;
   localparam int IW = 4;
   localparam int AW = $clog2(D);

   logic          clk = 1'b0;
   logic          rst;
   logic [N-1:0]  hit, mask;
   logic [AW-1:0] lat;
   logic          l0;
   logic          ev_valid;
   logic [N-1:0]  ev_word;
   logic [IW-1:0] ev_id;

   always #2 clk = ~clk;

   lvl0_edge_pipeline #(.NCH(N), .DEPTH(D), .ID_W(IW)) i_lvl0_edge_pipeline (
      .clk(clk), .rst(rst), .hit_i(hit), .mask_i(mask), .lat_i(lat), .l0_i(l0),
      .ev_valid_o(ev_valid), .ev_word_o(ev_word), .ev_id_o(ev_id)
   );

   int checks = 0;
   int errors = 0;
   logic [N-1:0]  hist [0:8191];
   int            cyc = 0;
   logic [N-1:0]  mprev;
   int            idc;
   logic          exp_v;
   logic [N-1:0]  exp_w;
   logic [IW-1:0] exp_id;
   logic [7:0]    lf = 8'h5B;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic next_rand();
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
   endtask

   task automatic step(input logic [N-1:0] h, input logic t, input string tag);
      logic [N-1:0] m;
      logic [N-1:0] ed;
      hit = h;
      l0  = t;
      @(posedge clk);
      m     = h & ~mask;
      ed    = m & ~mprev;
      mprev = m;
      exp_v = t;
      if (t) begin
         exp_w  = hist[cyc - int'(lat)];
         exp_id = IW'(idc);
         idc    = (idc + 1) % (1 << IW);
      end
      hist[cyc] = ed;
      cyc++;
      @(negedge clk);
      chk(ev_valid === exp_v, "R4 valid", int'(ev_valid), int'(exp_v));
      if (exp_v) begin
         chk(ev_word === exp_w, tag, int'(ev_word), int'(exp_w));
         chk(ev_id === exp_id, "R6 id", int'(ev_id), int'(exp_id));
      end else begin
         chk(ev_word === exp_w, "R7 word hold", int'(ev_word), int'(exp_w));
         chk(ev_id === exp_id, "R7 id hold", int'(ev_id), int'(exp_id));
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      hit = '0;
      l0  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ev_valid === 1'b0, "R8 valid", int'(ev_valid), 0);
      chk(ev_word === '0, "R8 word", int'(ev_word), 0);
      chk(ev_id === '0, "R8 id", int'(ev_id), 0);
      rst    = 1'b0;
      mprev  = '0;
      idc    = 0;
      exp_w  = '0;
      exp_id = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      mask = '0;
      lat  = AW'(1);
      do_reset();

      // R3, R5: every legal latency, with warm-up, a back-to-back burst and random accepts
      for (int L = 1; L < D; L++) begin
         lat = AW'(L);
         for (int i = 0; i < 16; i++) begin next_rand(); step(lf, 1'b0, "R3 word"); end
         for (int i = 0; i < 3; i++)  begin next_rand(); step(lf, 1'b1, "R5 word"); end
         for (int i = 0; i < 10; i++) begin next_rand(); step(lf, lf[0] ^ lf[6], "R3 word"); end
      end

      // R1: partial mask
      mask = 8'hA5;
      lat  = AW'(7);
      for (int i = 0; i < 30; i++) begin next_rand(); step(lf, lf[2], "R1 word"); end
      for (int i = 0; i < 8; i++) step(8'hFF, 1'b1, "R1 word");

      // R2: held-high pattern produces one marker
      mask = '0;
      lat  = AW'(3);
      for (int i = 0; i < 6; i++) step(8'h00, 1'b0, "R2 word");
      for (int i = 0; i < 10; i++) step(8'h3C, 1'b1, "R2 word");
      step(8'h00, 1'b1, "R2 word");
      for (int i = 0; i < 6; i++) step(8'h3C, 1'b1, "R2 word");

      // R6: identifier rollover during a long run of consecutive accepts
      lat = AW'(5);
      for (int i = 0; i < 40; i++) begin next_rand(); step(lf, 1'b1, "R6 word"); end

      // R8: reset mid-run, then restart from identifier 0
      do_reset();
      lat = AW'(2);
      for (int i = 0; i < 4; i++) begin next_rand(); step(lf, 1'b0, "R3 word"); end
      for (int i = 0; i < 5; i++) begin next_rand(); step(lf, 1'b1, "R6 word"); end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule